// File: doc/BRIEF.md
# Four-Context Dual-Pipe Issue Selector

This unit picks, each cycle, which of four hardware thread contexts of an in-order core may issue, and whether one or two instructions leave that context. Each context shows a head instruction and the one that follows it. Both carry a 3-bit class code, a destination register with a valid bit, and two source registers. The head always goes to the primary pipe. The follower may join it on the secondary pipe in the same cycle, but only when its class is allowed there and it does not touch the head's destination.

Contexts take turns in a rotating order. A context that issued in one cycle sits out the next, so at least two busy contexts are needed to fill every cycle. Each context has a scoreboard with one down-counter per register. The counter holds back a later instruction until the result it reads, or the register it overwrites, is complete. The surrounding core supplies the instruction streams and consumes the accept and issue outputs.

Class codes: 0 scalar, 1 vector arithmetic, 2 vector mask, 3 vector load, 4 vector store or scatter, 5 vector pack-store, 6 vector prefetch, 7 vector convert or shuffle.

Top module: `mt_issue_sched`

## Requirements
- R1: While `rst` is high, no issue strobe and no accept is raised. After reset the scoreboards are empty and the rotation starts at context 0.
- R2: The grant goes to the first eligible context found when searching upward, wrapping, from the rotation pointer. After a grant the pointer moves to the context just past the grantee.
- R3: A context that issued in the previous cycle is not granted in the current cycle.
- R4: When no context is eligible, `iss_pri`, `iss_sec` and `thr_acc` are all 0 and the rotation pointer keeps its value.
- R5: The head of the granted context issues on the primary pipe whatever its class.
- R6: The follower may issue on the secondary pipe only if its class is 0, 2, 4, 5 or 6. Classes 1, 3 and 7 never issue there. The secondary pipe never issues without the primary pipe.
- R7: The follower stays back when the head writes a register that the follower reads through either source or also writes.
- R8: After an instruction writes a register, a later instruction of the same context that reads it issues no sooner than L cycles after the writer. L is 4 for classes 1 and 2, and 1 for class 0; the one-cycle bar of R3 still applies.
- R9: L is 7 for classes 3, 4, 5 and 6.
- R10: L is 6 for class 7.
- R11: An instruction whose destination is still counting down in its context's scoreboard is held back by the same rule, so writes to a register keep their order.
- R12: `thr_acc` is one-hot at the position given by `sel_thr` whenever `iss_pri` is high, and zero otherwise.
- R13: A follower whose own sources or destination are still counting down stays back, and the head issues alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hd_vld | input | NTHR | Head instruction present, per context |
| hd_cls | input | NTHR x 3 | Head class code |
| hd_dst | input | NTHR x RW | Head destination register |
| hd_dv | input | NTHR | Head writes its destination |
| hd_s1 | input | NTHR x RW | Head first source register |
| hd_s2 | input | NTHR x RW | Head second source register |
| nx_vld | input | NTHR | Follower instruction present |
| nx_cls | input | NTHR x 3 | Follower class code |
| nx_dst | input | NTHR x RW | Follower destination register |
| nx_dv | input | NTHR | Follower writes its destination |
| nx_s1 | input | NTHR x RW | Follower first source register |
| nx_s2 | input | NTHR x RW | Follower second source register |
| iss_pri | output | 1 | Head of the selected context issues on the primary pipe |
| iss_sec | output | 1 | Follower of the selected context issues on the secondary pipe |
| sel_thr | output | TW | Selected context |
| thr_acc | output | NTHR | One-hot accept of the head, per context |

## Verification
The assertions take for granted that a context keeps showing the same head until it is accepted. They also assume the follower input is meaningful only together with a present head, and that a follower accepted on the secondary pipe is removed together with the head. The stimulus changes a context's instruction only in the cycle after its accept, or after a fresh reset. It keeps the follower present only where a head is also present. Where a context is stalled, every register it reads stays the same until the context is released.

// File: rtl/mt_issue_sched.sv
module mt_issue_sched #(
  parameter int NTHR    = 4,
  parameter int NREG    = 8,
  parameter int LAT_SCL = 1,
  parameter int LAT_VEC = 4,
  parameter int LAT_CVT = 6,
  parameter int LAT_MEM = 7
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [NTHR-1:0]                    hd_vld,
  input  logic [NTHR-1:0][2:0]               hd_cls,
  input  logic [NTHR-1:0][$clog2(NREG)-1:0]  hd_dst,
  input  logic [NTHR-1:0]                    hd_dv,
  input  logic [NTHR-1:0][$clog2(NREG)-1:0]  hd_s1,
  input  logic [NTHR-1:0][$clog2(NREG)-1:0]  hd_s2,
  input  logic [NTHR-1:0]                    nx_vld,
  input  logic [NTHR-1:0][2:0]               nx_cls,
  input  logic [NTHR-1:0][$clog2(NREG)-1:0]  nx_dst,
  input  logic [NTHR-1:0]                    nx_dv,
  input  logic [NTHR-1:0][$clog2(NREG)-1:0]  nx_s1,
  input  logic [NTHR-1:0][$clog2(NREG)-1:0]  nx_s2,
  output logic                               iss_pri,
  output logic                               iss_sec,
  output logic [$clog2(NTHR)-1:0]            sel_thr,
  output logic [NTHR-1:0]                    thr_acc
);
  localparam int TW = $clog2(NTHR);
  localparam int RW = $clog2(NREG);
  localparam int CW = $clog2(LAT_MEM + 1);

  logic [CW-1:0] sb [NTHR][NREG];
  logic [TW-1:0] ptr, last_t;
  logic          last_v;
  logic [NTHR-1:0] hd_ok;
  logic [TW-1:0] g;
  logic          g_ok, sec_ok;

  function automatic logic [CW-1:0] hold_of(input logic [2:0] c);
    case (c)
      3'd0:                hold_of = CW'(LAT_SCL - 1);
      3'd1, 3'd2:          hold_of = CW'(LAT_VEC - 1);
      3'd7:                hold_of = CW'(LAT_CVT - 1);
      default:             hold_of = CW'(LAT_MEM - 1);
    endcase
  endfunction

  function automatic logic sec_class(input logic [2:0] c);
    sec_class = (c == 3'd0) || (c == 3'd2) || (c == 3'd4) ||
                (c == 3'd5) || (c == 3'd6);
  endfunction

  always_comb begin
    for (int t = 0; t < NTHR; t++) begin
      hd_ok[t] = !rst && hd_vld[t]
               && !(last_v && (int'(last_t) == t))
               && (sb[t][hd_s1[t]] == '0) && (sb[t][hd_s2[t]] == '0)
               && !(hd_dv[t] && (sb[t][hd_dst[t]] != '0));
    end
  end

  always_comb begin
    g    = ptr;
    g_ok = 1'b0;
    for (int k = 0; k < NTHR; k++) begin
      int idx;
      idx = (int'(ptr) + k) % NTHR;
      if (!g_ok && hd_ok[idx]) begin
        g_ok = 1'b1;
        g    = TW'(idx);
      end
    end
  end

  always_comb begin
    sec_ok = g_ok && nx_vld[g] && sec_class(nx_cls[g])
           && (sb[g][nx_s1[g]] == '0) && (sb[g][nx_s2[g]] == '0)
           && !(nx_dv[g] && (sb[g][nx_dst[g]] != '0))
           && !(hd_dv[g] && ((nx_s1[g] == hd_dst[g]) || (nx_s2[g] == hd_dst[g]) ||
                             (nx_dv[g] && (nx_dst[g] == hd_dst[g]))));
  end

  assign iss_pri = g_ok;
  assign iss_sec = sec_ok;
  assign sel_thr = g;
  assign thr_acc = g_ok ? (NTHR'(1) << g) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr    <= '0;
      last_t <= '0;
      last_v <= 1'b0;
      for (int t = 0; t < NTHR; t++)
        for (int r = 0; r < NREG; r++)
          sb[t][r] <= '0;
    end else begin
      for (int t = 0; t < NTHR; t++)
        for (int r = 0; r < NREG; r++)
          if (sb[t][r] != '0) sb[t][r] <= sb[t][r] - CW'(1);
      if (g_ok && hd_dv[g])  sb[g][hd_dst[g]] <= hold_of(hd_cls[g]);
      if (sec_ok && nx_dv[g]) sb[g][nx_dst[g]] <= hold_of(nx_cls[g]);
      last_v <= g_ok;
      last_t <= g;
      if (g_ok) ptr <= TW'((int'(g) + 1) % NTHR);
    end
  end

  // R12
  always_comb onehot_acc_chk: assert ($onehot0(thr_acc));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |-> !iss_pri && !iss_sec && thr_acc == '0);

  // R6
  sec_needs_pri_chk: assert property (@(posedge clk) disable iff (rst)
    iss_sec |-> iss_pri);

  // R6
  sec_class_chk: assert property (@(posedge clk) disable iff (rst)
    iss_sec |-> (nx_cls[sel_thr] != 3'd1 && nx_cls[sel_thr] != 3'd3 && nx_cls[sel_thr] != 3'd7));

  // R3
  no_repeat_chk: assert property (@(posedge clk) disable iff (rst)
    iss_pri && $past(iss_pri) |-> sel_thr != $past(sel_thr));

  // R4
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !iss_pri |=> $stable(ptr));

  // R2
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    iss_pri |=> int'(ptr) == (int'($past(sel_thr)) + 1) % NTHR);
endmodule

// File: tb/mt_issue_sched_test.sv
`timescale 1ns/1ps
module mt_issue_sched_test;
  localparam int N  = 4;
  localparam int RW = 3;

  logic clk = 0;
  logic rst = 1;
  logic [N-1:0]          hd_vld, hd_dv, nx_vld, nx_dv;
  logic [N-1:0][2:0]     hd_cls, nx_cls;
  logic [N-1:0][RW-1:0]  hd_dst, hd_s1, hd_s2, nx_dst, nx_s1, nx_s2;
  logic                  iss_pri, iss_sec;
  logic [1:0]            sel_thr;
  logic [N-1:0]          thr_acc;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  mt_issue_sched uut (
    .clk(clk), .rst(rst),
    .hd_vld(hd_vld), .hd_cls(hd_cls), .hd_dst(hd_dst), .hd_dv(hd_dv),
    .hd_s1(hd_s1), .hd_s2(hd_s2),
    .nx_vld(nx_vld), .nx_cls(nx_cls), .nx_dst(nx_dst), .nx_dv(nx_dv),
    .nx_s1(nx_s1), .nx_s2(nx_s2),
    .iss_pri(iss_pri), .iss_sec(iss_sec), .sel_thr(sel_thr), .thr_acc(thr_acc)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_in();
    hd_vld = '0; hd_cls = '0; hd_dst = '0; hd_dv = '0; hd_s1 = '0; hd_s2 = '0;
    nx_vld = '0; nx_cls = '0; nx_dst = '0; nx_dv = '0; nx_s1 = '0; nx_s2 = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    clear_in();
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1;
    hd_vld = '1;
    #5;
    chk(!iss_pri && !iss_sec && thr_acc == 0, "R1 quiet in reset", int'(iss_pri), 0);
    @(negedge clk);
    rst = 0;
    #5;
    chk(iss_pri && sel_thr == 0, "R1 first grant ctx0", int'(sel_thr), 0);
  endtask

  task automatic t_rotate();
    do_reset();
    hd_vld = '1;
    for (int i = 0; i < 8; i++) begin
      if (i > 0) @(negedge clk);
      #5;
      chk(iss_pri && sel_thr == 2'(i % N), "R2 rotation", int'(sel_thr), i % N);
      chk(thr_acc == (4'b1 << (i % N)), "R12 accept onehot", int'(thr_acc), 1 << (i % N));
    end
  endtask

  task automatic t_alone();
    do_reset();
    hd_vld[2] = 1;
    #5;
    chk(iss_pri && sel_thr == 2, "R3 lone ctx issue", int'(sel_thr), 2);
    @(negedge clk); #5;
    chk(!iss_pri && thr_acc == 0, "R3 lone ctx barred", int'(iss_pri), 0);
    @(negedge clk); #5;
    chk(iss_pri && sel_thr == 2, "R3 lone ctx again", int'(sel_thr), 2);
  endtask

  task automatic t_hold();
    do_reset();
    hd_vld[3] = 1;
    #5;
    chk(iss_pri && sel_thr == 3, "R2 grant ctx3", int'(sel_thr), 3);
    @(negedge clk); #5;
    chk(!iss_pri && !iss_sec && thr_acc == 0, "R4 nothing eligible", int'(thr_acc), 0);
    @(negedge clk);
    hd_vld = 4'b0101;
    #5;
    chk(iss_pri && sel_thr == 0, "R4 pointer held", int'(sel_thr), 0);
    @(negedge clk); #5;
    chk(iss_pri && sel_thr == 2, "R2 skip barred ctx", int'(sel_thr), 2);
  endtask

  task automatic t_pair_class();
    for (int c = 0; c < 8; c++) begin
      bit allow;
      allow = (c == 0) || (c == 2) || (c == 4) || (c == 5) || (c == 6);
      do_reset();
      hd_vld[0] = 1; hd_cls[0] = 3'd1;
      nx_vld[0] = 1; nx_cls[0] = 3'(c);
      #5;
      chk(iss_pri, "R5 head on primary", int'(iss_pri), 1);
      chk(iss_sec == allow, "R6 secondary class", int'(iss_sec), int'(allow));
    end
  endtask

  task automatic t_pair_dep();
    do_reset();
    hd_vld[1] = 1; hd_cls[1] = 3'd1; hd_dst[1] = 3; hd_dv[1] = 1;
    nx_vld[1] = 1; nx_cls[1] = 3'd0; nx_s1[1] = 3;
    #5;
    chk(iss_pri && !iss_sec, "R7 follower reads head dst", int'(iss_sec), 0);
    do_reset();
    hd_vld[1] = 1; hd_cls[1] = 3'd1; hd_dst[1] = 3; hd_dv[1] = 1;
    nx_vld[1] = 1; nx_cls[1] = 3'd0; nx_dst[1] = 3; nx_dv[1] = 1;
    #5;
    chk(iss_pri && !iss_sec, "R7 follower writes head dst", int'(iss_sec), 0);
    do_reset();
    hd_vld[1] = 1; hd_cls[1] = 3'd1; hd_dst[1] = 3; hd_dv[1] = 1;
    nx_vld[1] = 1; nx_cls[1] = 3'd0; nx_s2[1] = 4; nx_dst[1] = 5; nx_dv[1] = 1;
    #5;
    chk(iss_pri && iss_sec, "R7 independent follower pairs", int'(iss_sec), 1);
  endtask

  task automatic lat_probe(input int cls, input bit waw, input int exp, input string req);
    int got;
    got = -1;
    do_reset();
    hd_vld[0] = 1; hd_cls[0] = 3'(cls); hd_dst[0] = 2; hd_dv[0] = 1;
    #5;
    chk(iss_pri && sel_thr == 0, {req, " writer issues"}, int'(iss_pri), 1);
    @(negedge clk);
    hd_cls[0] = 3'd0;
    if (waw) begin hd_dst[0] = 2; hd_dv[0] = 1; hd_s1[0] = 0; end
    else     begin hd_dv[0] = 0; hd_s1[0] = 2; end
    for (int i = 1; i < 14; i++) begin
      if (i > 1) @(negedge clk);
      #5;
      if (iss_pri && got < 0) got = i;
    end
    chk(got == exp, req, got, exp);
  endtask

  task automatic t_follow_busy();
    do_reset();
    hd_vld[0] = 1; hd_cls[0] = 3'd1; hd_dst[0] = 2; hd_dv[0] = 1;
    #5;
    chk(iss_pri, "R13 writer issues", int'(iss_pri), 1);
    @(negedge clk);
    hd_cls[0] = 3'd0; hd_dv[0] = 0; hd_dst[0] = 0;
    nx_vld[0] = 1; nx_cls[0] = 3'd0; nx_s1[0] = 2;
    #5;
    chk(!iss_pri, "R13 barred cycle", int'(iss_pri), 0);
    @(negedge clk); #5;
    chk(iss_pri && !iss_sec, "R13 head alone, follower busy", int'(iss_sec), 0);
  endtask

  initial begin
    clear_in();
    t_reset();
    t_rotate();
    t_alone();
    t_hold();
    t_pair_class();
    t_pair_dep();
    lat_probe(1, 0, 4, "R8 vector arith latency");
    lat_probe(2, 0, 4, "R8 vector mask latency");
    lat_probe(0, 0, 2, "R8 scalar latency");
    lat_probe(3, 0, 7, "R9 load latency");
    lat_probe(4, 0, 7, "R9 store latency");
    lat_probe(6, 0, 7, "R9 prefetch latency");
    lat_probe(7, 0, 6, "R10 convert latency");
    lat_probe(3, 1, 7, "R11 dest busy");
    t_follow_busy();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3000000;
    total++;
    bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule